// File: doc/BRIEF.md
# Configurable Fault Response Manager

This block collects the fault conditions of a three-phase motor driver and decides what the chip does about each one. The inputs are overcurrent per half-bridge (high side and low side of every phase), supply undervoltage, overtemperature shutdown, overtemperature warning and a communication fault. The outputs are a global fault flag, an active-low fault pin, a command that puts the power stage into high impedance, and one readable status bit per condition.

Every fault class follows its own policy. It can retry automatically after a slow or a fast recovery time, latch until a clear command, report without touching the drivers, or be disabled. The two recovery times come from four-entry tables of tick counts. The tables are parameters, and a 2-bit select picks one entry from each. The timers advance only on a timebase tick input, so one table entry is a whole number of ticks. Comparators, deglitch and blanking circuits, and the register access path are outside the block. They reach it as synchronous inputs and configuration ports.

Top module: `fault_resp_mgr`

## Requirements
- R1: While `rst` is high, and after it is released with all inputs idle, every status bit, `fault_o` and `hiz_o` read 0, and `nfault_o` reads 1.
- R2: Overcurrent status is held per switch. `oc_sts_o[i]` belongs to `oc_ls_i[i]` and `oc_sts_o[NPH+i]` belongs to `oc_hs_i[i]`. A fault on one switch sets no other status bit. `oc_o` is 1 while any of the six overcurrent status bits is 1.
- R3: A class in retry mode sets its status on the clock edge that first sees its fault and raises `hiz_o`. The status then stays 1 for exactly P ticks, where P is the slow table entry chosen by `slow_sel_i` (slow retry) or the fast table entry chosen by `fast_sel_i` (fast retry). The overcurrent mode codes are: 0 = slow retry, 1 = fast retry, 2 = latch, 3 = report only, 7 = disabled.
- R4: If the fault is still present on the tick that ends the retry time, the timer restarts for another P ticks. If the fault input is held for L edges with tick on every cycle, the status stays 1 for P*ceil(L/P) cycles.
- R5: In latch mode the status stays 1 until a `clr_i` pulse arrives in a cycle without the fault. When `clr_i` and the fault fall in the same cycle, the status stays 1.
- R6: In report-only mode the status follows the fault input one cycle later and drives `nfault_o` low. It never raises `hiz_o`.
- R7: An overcurrent mode of 7, or a reserved code 4 to 6, disables the class: no status, no fault output and no high-impedance command.
- R8: The undervoltage and overtemperature-shutdown modes are 2 bits wide. Code 0 selects slow retry. Code 1 and the reserved codes 2 and 3 select fast retry. Both retry modes command high impedance.
- R9: `otw_sts_o` follows the warning input one cycle later whatever the enable. The warning pulls `fault_o` and `nfault_o` only while `otw_en_i` is 1. It never raises `hiz_o`.
- R10: With `comm_off_i` = 0 a communication fault latches `comm_sts_o` and the fault output until `clr_i`. With `comm_off_i` = 1 the input is ignored and the status stays 0.
- R11: `hiz_o` is 1 only while `fault_o` is 1, and `nfault_o` is always the inverse of `fault_o`.
- R12: A retry timer does not advance in cycles where `tick_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase pulse for the retry timers |
| oc_hs_i | input | NPH | Overcurrent on each high-side switch |
| oc_ls_i | input | NPH | Overcurrent on each low-side switch |
| uv_i | input | 1 | Supply undervoltage |
| ots_i | input | 1 | Overtemperature shutdown |
| otw_i | input | 1 | Overtemperature warning |
| comm_i | input | 1 | Communication fault event |
| oc_mode_i | input | 3 | Overcurrent policy code |
| uv_mode_i | input | 2 | Undervoltage policy code |
| ots_mode_i | input | 2 | Overtemperature-shutdown policy code |
| otw_en_i | input | 1 | Warning drives the fault output when 1 |
| comm_off_i | input | 1 | Communication fault ignored when 1 |
| slow_sel_i | input | 2 | Slow retry table select |
| fast_sel_i | input | 2 | Fast retry table select |
| clr_i | input | 1 | One-cycle clear of latched faults |
| oc_sts_o | output | 2*NPH | Per-switch overcurrent status |
| oc_o | output | 1 | Any overcurrent status |
| uv_sts_o | output | 1 | Undervoltage status |
| ots_sts_o | output | 1 | Overtemperature-shutdown status |
| otw_sts_o | output | 1 | Overtemperature-warning status |
| comm_sts_o | output | 1 | Communication fault status |
| fault_o | output | 1 | Global fault flag |
| nfault_o | output | 1 | Active-low fault output |
| hiz_o | output | 1 | Power stage high-impedance command |

## Verification
Two events can fall in the same cycle: a clear command and a fault that is still present on a latched class. The same kind of collision occurs when a retry timer expires in a cycle where its fault is still asserted. The bench drives `clr_i` in the cycle where it re-raises the overcurrent input, and it expects the status to survive that edge and to fall only on a later clear with the input low. For the expiry collision it holds each fault for several edges beyond the table period and compares the number of cycles the status stays high against P*ceil(L/P), computed for every mode and table select.

// File: rtl/fault_resp_pkg.sv
package fault_resp_pkg;

    typedef enum logic [2:0] {
        ACT_OFF        = 3'd0,
        ACT_REPORT     = 3'd1,
        ACT_LATCH      = 3'd2,
        ACT_RETRY_SLOW = 3'd3,
        ACT_RETRY_FAST = 3'd4
    } act_e;

    typedef struct packed {
        logic sts;
        logic hiz;
    } cls_out_t;

    function automatic act_e decode_oc(input logic [2:0] code);
        case (code)
            3'd0:    return ACT_RETRY_SLOW;
            3'd1:    return ACT_RETRY_FAST;
            3'd2:    return ACT_LATCH;
            3'd3:    return ACT_REPORT;
            default: return ACT_OFF;
        endcase
    endfunction

    function automatic act_e decode_sup(input logic [1:0] code);
        if (code == 2'd0) return ACT_RETRY_SLOW;
        return ACT_RETRY_FAST;
    endfunction

    function automatic logic is_retry(input act_e a);
        return (a == ACT_RETRY_SLOW) || (a == ACT_RETRY_FAST);
    endfunction

endpackage

// File: rtl/retry_period_sel.sv
module retry_period_sel
    import fault_resp_pkg::*;
#(
    parameter int TMR_W   = 24,
    parameter int SLOW_T0 = 500000,
    parameter int SLOW_T1 = 1000000,
    parameter int SLOW_T2 = 2000000,
    parameter int SLOW_T3 = 5000000,
    parameter int FAST_T0 = 500,
    parameter int FAST_T1 = 1000,
    parameter int FAST_T2 = 2000,
    parameter int FAST_T3 = 5000
) (
    input  logic [1:0]       slow_sel_i,
    input  logic [1:0]       fast_sel_i,
    output logic [TMR_W-1:0] slow_ticks_o,
    output logic [TMR_W-1:0] fast_ticks_o
);
    localparam logic [TMR_W-1:0] SLOW_TAB [4] = '{
        TMR_W'(SLOW_T0), TMR_W'(SLOW_T1), TMR_W'(SLOW_T2), TMR_W'(SLOW_T3)};
    localparam logic [TMR_W-1:0] FAST_TAB [4] = '{
        TMR_W'(FAST_T0), TMR_W'(FAST_T1), TMR_W'(FAST_T2), TMR_W'(FAST_T3)};

    always_comb begin
        slow_ticks_o = SLOW_TAB[slow_sel_i];
        fast_ticks_o = FAST_TAB[fast_sel_i];
    end
endmodule

// File: rtl/fault_class_ctrl.sv
module fault_class_ctrl
    import fault_resp_pkg::*;
#(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             raw_i,
    input  act_e             act_i,
    input  logic             clr_i,
    input  logic [TMR_W-1:0] slow_ticks_i,
    input  logic [TMR_W-1:0] fast_ticks_i,
    output cls_out_t         out_o
);
    logic             sts_q;
    logic [TMR_W-1:0] cnt_q;
    logic [TMR_W-1:0] period;
    logic             expire;

    assign period = (act_i == ACT_RETRY_SLOW) ? slow_ticks_i : fast_ticks_i;
    assign expire = tick_i && (cnt_q <= TMR_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            case (act_i)
                ACT_OFF: begin
                    sts_q <= 1'b0;
                    cnt_q <= '0;
                end
                ACT_REPORT: begin
                    sts_q <= raw_i;
                    cnt_q <= '0;
                end
                ACT_LATCH: begin
                    sts_q <= raw_i | (sts_q & ~clr_i);
                    cnt_q <= '0;
                end
                default: begin
                    if (!sts_q) begin
                        sts_q <= raw_i;
                        cnt_q <= period;
                    end else if (expire) begin
                        if (raw_i) cnt_q <= period;
                        else       sts_q <= 1'b0;
                    end else if (tick_i) begin
                        cnt_q <= cnt_q - TMR_W'(1);
                    end
                end
            endcase
        end
    end

    always_comb begin
        out_o.sts = sts_q;
        out_o.hiz = sts_q && ((act_i == ACT_LATCH) || is_retry(act_i));
    end

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_OFF) |=> !sts_q); // R7
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_LATCH && sts_q && !clr_i) |=> sts_q); // R5
    AST_FAULT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_LATCH && raw_i && clr_i) |=> sts_q); // R5
    AST_REPORT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_REPORT) |=> (sts_q == $past(raw_i))); // R6
    AST_RETRY_RESTART: assert property (@(posedge clk) disable iff (rst)
        (is_retry(act_i) && sts_q && expire && raw_i) |=> sts_q); // R4
    AST_RETRY_ENDS: assert property (@(posedge clk) disable iff (rst)
        (is_retry(act_i) && sts_q && expire && !raw_i) |=> !sts_q); // R3
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (is_retry(act_i) && sts_q && !tick_i) |=> sts_q); // R12
endmodule

// File: rtl/fault_resp_mgr.sv
module fault_resp_mgr
    import fault_resp_pkg::*;
#(
    parameter int NPH     = 3,
    parameter int TMR_W   = 24,
    parameter int SLOW_T0 = 500000,
    parameter int SLOW_T1 = 1000000,
    parameter int SLOW_T2 = 2000000,
    parameter int SLOW_T3 = 5000000,
    parameter int FAST_T0 = 500,
    parameter int FAST_T1 = 1000,
    parameter int FAST_T2 = 2000,
    parameter int FAST_T3 = 5000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [NPH-1:0]   oc_hs_i,
    input  logic [NPH-1:0]   oc_ls_i,
    input  logic             uv_i,
    input  logic             ots_i,
    input  logic             otw_i,
    input  logic             comm_i,
    input  logic [2:0]       oc_mode_i,
    input  logic [1:0]       uv_mode_i,
    input  logic [1:0]       ots_mode_i,
    input  logic             otw_en_i,
    input  logic             comm_off_i,
    input  logic [1:0]       slow_sel_i,
    input  logic [1:0]       fast_sel_i,
    input  logic             clr_i,
    output logic [2*NPH-1:0] oc_sts_o,
    output logic             oc_o,
    output logic             uv_sts_o,
    output logic             ots_sts_o,
    output logic             otw_sts_o,
    output logic             comm_sts_o,
    output logic             fault_o,
    output logic             nfault_o,
    output logic             hiz_o
);
    localparam int NSW  = 2 * NPH;
    localparam int NCLS = NSW + 2;

    logic [TMR_W-1:0] slow_ticks, fast_ticks;
    logic [NCLS-1:0]  raw_vec;
    act_e             act_vec [NCLS];
    cls_out_t         cls_out [NCLS];
    logic [NCLS-1:0]  sts_vec, hiz_vec;
    logic             otw_q, comm_q;

    retry_period_sel #(
        .TMR_W(TMR_W),
        .SLOW_T0(SLOW_T0), .SLOW_T1(SLOW_T1), .SLOW_T2(SLOW_T2), .SLOW_T3(SLOW_T3),
        .FAST_T0(FAST_T0), .FAST_T1(FAST_T1), .FAST_T2(FAST_T2), .FAST_T3(FAST_T3)
    ) u_period (
        .slow_sel_i  (slow_sel_i),
        .fast_sel_i  (fast_sel_i),
        .slow_ticks_o(slow_ticks),
        .fast_ticks_o(fast_ticks)
    );

    assign raw_vec = {ots_i, uv_i, oc_hs_i, oc_ls_i};

    for (genvar i = 0; i < NCLS; i++) begin : g_cls
        if (i < NSW) begin : g_oc
            assign act_vec[i] = decode_oc(oc_mode_i);
        end else if (i == NSW) begin : g_uv
            assign act_vec[i] = decode_sup(uv_mode_i);
        end else begin : g_ots
            assign act_vec[i] = decode_sup(ots_mode_i);
        end

        fault_class_ctrl #(.TMR_W(TMR_W)) u_ctrl (
            .clk         (clk),
            .rst         (rst),
            .tick_i      (tick_i),
            .raw_i       (raw_vec[i]),
            .act_i       (act_vec[i]),
            .clr_i       (clr_i),
            .slow_ticks_i(slow_ticks),
            .fast_ticks_i(fast_ticks),
            .out_o       (cls_out[i])
        );

        assign sts_vec[i] = cls_out[i].sts;
        assign hiz_vec[i] = cls_out[i].hiz;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            otw_q  <= 1'b0;
            comm_q <= 1'b0;
        end else begin
            otw_q  <= otw_i;
            comm_q <= !comm_off_i && (comm_i || (comm_q && !clr_i));
        end
    end

    always_comb begin
        oc_sts_o   = sts_vec[NSW-1:0];
        oc_o       = |sts_vec[NSW-1:0];
        uv_sts_o   = sts_vec[NSW];
        ots_sts_o  = sts_vec[NSW+1];
        otw_sts_o  = otw_q;
        comm_sts_o = comm_q;
        fault_o    = (|sts_vec) || (otw_q && otw_en_i) || comm_q;
        nfault_o   = !fault_o;
        hiz_o      = |hiz_vec;
    end

    AST_HIZ_NEEDS_FAULT: assert property (@(posedge clk) disable iff (rst)
        hiz_o |-> (fault_o && !nfault_o)); // R11
    AST_COMM_IGNORED: assert property (@(posedge clk) disable iff (rst)
        comm_off_i |=> !comm_sts_o); // R10
    AST_COMM_FAULT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!comm_off_i && comm_i) |=> comm_sts_o); // R10
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!fault_o && !hiz_o && nfault_o)); // R1
endmodule

// File: tb/fault_resp_mgr_tb.sv
module fault_resp_mgr_tb;
    localparam int NPH = 3;
    localparam int CAP = 64;
    localparam int SLOW [4] = '{9, 12, 16, 21};
    localparam int FAST [4] = '{2, 3, 5, 7};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_i = 1'b1;
    logic [NPH-1:0] oc_hs_i = '0, oc_ls_i = '0;
    logic uv_i = 0, ots_i = 0, otw_i = 0, comm_i = 0;
    logic [2:0] oc_mode_i = 3'd7;
    logic [1:0] uv_mode_i = 2'd1, ots_mode_i = 2'd1;
    logic otw_en_i = 0, comm_off_i = 0, clr_i = 0;
    logic [1:0] slow_sel_i = 0, fast_sel_i = 0;
    logic [2*NPH-1:0] oc_sts_o;
    logic oc_o, uv_sts_o, ots_sts_o, otw_sts_o, comm_sts_o, fault_o, nfault_o, hiz_o;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    fault_resp_mgr #(
        .NPH(NPH), .TMR_W(8),
        .SLOW_T0(9), .SLOW_T1(12), .SLOW_T2(16), .SLOW_T3(21),
        .FAST_T0(2), .FAST_T1(3), .FAST_T2(5), .FAST_T3(7)
    ) u_dut (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_raw(input int idx, input logic v);
        if (idx < NPH)          oc_ls_i[idx] = v;
        else if (idx < 2 * NPH) oc_hs_i[idx-NPH] = v;
        else if (idx == 2 * NPH) uv_i = v;
        else                     ots_i = v;
    endtask

    function automatic logic get_sts(input int idx);
        if (idx < 2 * NPH) return oc_sts_o[idx];
        if (idx == 2 * NPH) return uv_sts_o;
        return ots_sts_o;
    endfunction

    task automatic run(input int idx, input int len, output int hi, output int hz,
                       output int nf, output int oca, output int other);
        hi = 0; hz = 0; nf = 0; oca = 0; other = 0;
        @(negedge clk);
        set_raw(idx, 1'b1);
        for (int c = 0; c < CAP; c++) begin
            @(negedge clk);
            if (get_sts(idx)) hi++;
            if (hiz_o) hz = 1;
            if (!nfault_o) nf = 1;
            if (oc_o) oca = 1;
            for (int j = 0; j < 2 * NPH; j++)
                if (j != idx && oc_sts_o[j]) other = 1;
            if (c + 1 == len) set_raw(idx, 1'b0);
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr_i = 1;
        @(negedge clk); clr_i = 0;
    endtask

    function automatic int span(input int p, input int len);
        return ((len + p - 1) / p) * p;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int hi, hz, nf, oca, oth, exp, m;
        int modes [6] = '{0, 1, 2, 3, 5, 7};
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 fault in reset", fault_o, 0);
        check("R1 nfault in reset", nfault_o, 1);
        rst = 0;
        @(negedge clk); @(negedge clk);
        check("R1 status idle", {oc_sts_o, uv_sts_o, ots_sts_o, otw_sts_o, comm_sts_o}, 0);
        check("R1 hiz idle", hiz_o, 0);
        check("R1 nfault idle", nfault_o, 1);

        // Overcurrent sweep: R2 R3 R4 R5 R6 R7
        for (int b = 0; b < 2 * NPH; b++)
            for (int mi = 0; mi < 6; mi++)
                for (int li = 0; li < 2; li++) begin
                    int len;
                    len = (li == 0) ? 1 : 4;
                    m = modes[mi];
                    oc_mode_i = 3'(m);
                    slow_sel_i = 2'(b % 4);
                    fast_sel_i = 2'((b + mi) % 4);
                    run(b, len, hi, hz, nf, oca, oth);
                    case (m)
                        0: exp = span(SLOW[b % 4], len);
                        1: exp = span(FAST[(b + mi) % 4], len);
                        2: exp = CAP;
                        3: exp = len;
                        default: exp = 0;
                    endcase
                    if (m == 0 || m == 1) check("R3/R4 oc retry span", hi, exp);
                    else if (m == 2)      check("R5 oc latched span", hi, exp);
                    else if (m == 3)      check("R6 oc report span", hi, exp);
                    else                  check("R7 oc disabled span", hi, exp);
                    check("R11 oc hiz", hz, (exp > 0 && m <= 2) ? 1 : 0);
                    check("R6 nfault low", nf, (exp > 0) ? 1 : 0);
                    check("R2 oc summary", oca, (exp > 0) ? 1 : 0);
                    check("R2 other bits clear", oth, 0);
                    if (m == 2) begin
                        pulse_clr();
                        check("R5 clear releases latch", oc_sts_o[b], 0);
                    end
                end

        // Supply classes: R8 R3 R4 R11
        for (int idx = 2 * NPH; idx < 2 * NPH + 2; idx++)
            for (int md = 0; md < 4; md++)
                for (int s = 0; s < 4; s++)
                    for (int li = 0; li < 2; li++) begin
                        int len;
                        len = (li == 0) ? 1 : 5;
                        uv_mode_i = 2'(md); ots_mode_i = 2'(md);
                        slow_sel_i = 2'(s); fast_sel_i = 2'(3 - s);
                        run(idx, len, hi, hz, nf, oca, oth);
                        exp = (md == 0) ? span(SLOW[s], len) : span(FAST[3 - s], len);
                        check("R8 supply retry span", hi, exp);
                        check("R11 supply hiz", hz, 1);
                        check("R2 supply leaves oc clear", oca, 0);
                    end

        // R5 clear in the same cycle as a present fault
        oc_mode_i = 3'd2;
        @(negedge clk); oc_hs_i[1] = 1;
        @(negedge clk); oc_hs_i[1] = 0;
        @(negedge clk); oc_hs_i[1] = 1; clr_i = 1;
        @(negedge clk); oc_hs_i[1] = 0; clr_i = 0;
        check("R5 fault beats clear", oc_sts_o[NPH+1], 1);
        check("R2 high-side bit position", oc_sts_o, 1 << (NPH + 1));
        @(negedge clk);
        check("R5 latch holds", oc_sts_o[NPH+1], 1);
        pulse_clr();
        check("R5 clear without fault", oc_sts_o[NPH+1], 0);
        oc_mode_i = 3'd7;

        // R9 warning
        otw_en_i = 0;
        @(negedge clk); otw_i = 1;
        @(negedge clk);
        check("R9 warning status", otw_sts_o, 1);
        check("R9 masked warning nfault", nfault_o, 1);
        otw_en_i = 1;
        #1;
        check("R9 enabled warning nfault", nfault_o, 0);
        check("R9 warning no hiz", hiz_o, 0);
        @(negedge clk); otw_i = 0; otw_en_i = 0;
        @(negedge clk);
        check("R9 warning released", otw_sts_o, 0);

        // R10 communication fault
        comm_off_i = 1;
        @(negedge clk); comm_i = 1;
        @(negedge clk); comm_i = 0;
        @(negedge clk);
        check("R10 ignored comm", comm_sts_o, 0);
        check("R10 ignored comm nfault", nfault_o, 1);
        comm_off_i = 0;
        @(negedge clk); comm_i = 1;
        @(negedge clk); comm_i = 0;
        repeat (5) @(negedge clk);
        check("R10 comm latched", comm_sts_o, 1);
        check("R10 comm nfault", nfault_o, 0);
        check("R10 comm no hiz", hiz_o, 0);
        pulse_clr();
        check("R10 comm cleared", comm_sts_o, 0);

        // R12 tick gating
        uv_mode_i = 2'd1; fast_sel_i = 2'd0;
        tick_i = 0;
        @(negedge clk); uv_i = 1;
        @(negedge clk); uv_i = 0;
        repeat (20) @(negedge clk);
        check("R12 no tick keeps status", uv_sts_o, 1);
        tick_i = 1;
        repeat (FAST[0]) @(negedge clk);
        check("R12 ticks resume expiry", uv_sts_o, 0);
        check("R11 hiz released", hiz_o, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule